// File: doc/BRIEF.md
# Two-Wire Addressed Slave Front End

This block is the bus-facing half of a small register-based slave device on a two-wire serial bus with one clock line and one open-drain data line. It oversamples both lines on the system clock and filters out short glitches. From the filtered lines it detects start and stop conditions and clock edges. A transaction opens with an address byte, which the block matches against a fixed device-type nibble and four strap pins.

When the address matches, the block takes in an instruction byte. Depending on the opcode it then does one of three things: it takes in a data byte from the master, it shifts a register value out to the master, or it enters an open-ended stepping phase. In the stepping phase every clock pulse asks the register executor to move a counter one position up or down.

The block hands the opcode, the pointer and the received data to a separate register executor. It takes read data and a busy flag back from that executor. It tells the executor when a stop has closed a complete command, so that a long internal write can begin. While that write is in progress, the block refuses to acknowledge its address, which lets the master poll for completion. The data line is driven only through an output-enable that pulls the line low.

Top module: `twowire_slave_fe`

## Requirements
- R1: A pulse on SCL or SDA lasting fewer than FILT_LEN system clocks (default 3) after synchronization has no effect: a 2-clock low glitch on SDA while SCL is high in the middle of an address byte neither ends nor restarts the transaction.
- R2: After reset the block is idle with `sda_oe_o` low. A start (SDA falling while SCL is high) in any state begins a new address byte, including a repeated start in the middle of a command. A stop (SDA rising while SCL is high) returns the block to idle.
- R3: The address byte is received MSB first. It is acknowledged, by driving `sda_oe_o` high during the ninth clock, only when bits 7:4 equal 4'b0101 and bits 3:0 equal `dev_addr_i`, with dev_addr_i[3] compared against bit 3.
- R4: After an address that does not match, the block acknowledges nothing, issues no strobe and reports no finished command until the next start.
- R5: While `nv_busy_i` is high at the eighth address bit, a matching address is not acknowledged.
- R6: After an acknowledged address, the next byte is always acknowledged. `instr_stb_o` pulses for one cycle, with `opcode_o` = bits 7:4 and `pointer_o` = bits 3:0 of that byte.
- R7: For opcodes 4'b1010 and 4'b1100, a third byte from the master is acknowledged, and `wdata_stb_o` pulses with `wdata_o` equal to that byte.
- R8: For opcodes 4'b1001 and 4'b1011, the block sends {2'b00, rd_val_i} MSB first during the eight clocks after the instruction acknowledge. It then releases SDA for the master's acknowledge bit.
- R9: For opcode 4'b0010, each complete SCL pulse after the instruction acknowledge produces one `step_stb_o` pulse. `step_up_o` is 1 if SDA was high at the rising SCL edge and 0 if it was low. This continues until a stop. The clock edge that precedes a stop or repeated start produces no step.
- R10: `cmd_done_o` pulses once on the stop that closes a complete command. A command is complete once its instruction has been acknowledged (all other opcodes), its data byte has been acknowledged (R7 opcodes), its read byte has been sent (R8 opcodes), or its stepping phase has begun (R9 opcode). A stop after an incomplete command produces no pulse.
- R11: `sda_oe_o` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr_i | input | 4 | Strap pins compared with the low address nibble |
| nv_busy_i | input | 1 | Executor's internal write is in progress |
| rd_val_i | input | RD_W | Register value to send for read opcodes |
| sda_oe_o | output | 1 | Pull SDA low when high |
| instr_stb_o | output | 1 | One-cycle pulse when an instruction byte has arrived |
| opcode_o | output | 4 | Opcode of the last instruction |
| pointer_o | output | 4 | Register/channel pointer of the last instruction |
| wdata_stb_o | output | 1 | One-cycle pulse when a data byte has arrived |
| wdata_o | output | 8 | Last data byte received |
| step_stb_o | output | 1 | One-cycle step request in the stepping phase |
| step_up_o | output | 1 | Direction of the step: 1 up, 0 down |
| cmd_done_o | output | 1 | One-cycle pulse on a stop that closes a complete command |

## Verification
Two functions can fall together at the end of the stepping phase. A clock rise has already latched a step direction when a repeated start arrives, so the step logic and the start detector both act on the same pending state. The bench provokes this by issuing three steps and then a repeated start without a further falling clock. It judges the result by an exact count of step pulses and up steps, by the acknowledge of the following address byte, and by a single completion pulse on the final stop. A second collision, busy raised at the eighth address bit, is provoked in random and directed transactions and judged by a missing acknowledge.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam logic [3:0] TYPE_ID      = 4'b0101;
    localparam logic [3:0] OP_RD_LIVE   = 4'b1001;
    localparam logic [3:0] OP_WR_LIVE   = 4'b1010;
    localparam logic [3:0] OP_RD_STORE  = 4'b1011;
    localparam logic [3:0] OP_WR_STORE  = 4'b1100;
    localparam logic [3:0] OP_STEP      = 4'b0010;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_WDATA,
        PH_ACK,
        PH_RDATA,
        PH_MACK,
        PH_STEP,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    function automatic phase_e phase_after_instr(input logic [3:0] op);
        phase_e ph;
        case (op)
            OP_RD_LIVE, OP_RD_STORE: ph = PH_RDATA;
            OP_WR_LIVE, OP_WR_STORE: ph = PH_WDATA;
            OP_STEP:                 ph = PH_STEP;
            default:                 ph = PH_HOLD;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILT_LEN-1:0]    hist;
        logic                   filt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], line_i};
        st_d.hist = {st_q.hist[FILT_LEN-2:0], st_q.sync[SYNC_STAGES-1]};
        if (&st_q.hist) begin
            st_d.filt = 1'b1;
        end else if (~|st_q.hist) begin
            st_d.filt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.filt;

    // a filtered transition is never followed by another one in the next cycle
    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |=> $stable(st_q.filt)); // R1

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
    } ev_st_t;

    ev_st_t st_d, st_q;

    always_comb begin
        st_d.scl_prev = scl_f;
        st_d.sda_prev = sda_f;
        ev_o.start    = scl_f & st_q.scl_prev & st_q.sda_prev & ~sda_f;
        ev_o.stop     = scl_f & st_q.scl_prev & ~st_q.sda_prev & sda_f;
        ev_o.scl_rise = scl_f & ~st_q.scl_prev;
        ev_o.scl_fall = ~scl_f & st_q.scl_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_o.start, ev_o.stop, ev_o.scl_rise, ev_o.scl_fall})); // R2

endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter int RD_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_ev_t         ev,
    input  logic            scl_f,
    input  logic            sda_f,
    input  logic [3:0]      dev_addr_i,
    input  logic            nv_busy_i,
    input  logic [RD_W-1:0] rd_val_i,
    output logic            sda_oe_o,
    output logic            instr_stb_o,
    output logic [3:0]      opcode_o,
    output logic [3:0]      pointer_o,
    output logic            wdata_stb_o,
    output logic [7:0]      wdata_o,
    output logic            step_stb_o,
    output logic            step_up_o,
    output logic            cmd_done_o
);

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e             phase;
        phase_e             after_ack;
        logic               ack;
        logic [BYTE_W-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic               byte_done;
        logic               oe;
        logic [3:0]         op;
        logic [3:0]         ptr;
        logic [BYTE_W-1:0]  wdata;
        logic               instr_stb;
        logic               wdata_stb;
        logic               step_stb;
        logic               step_up;
        logic               dir;
        logic               done_stb;
        logic               complete;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic [BYTE_W-1:0] byte_nx;
    logic [BYTE_W-1:0] sh_ld;

    always_comb begin
        st_d           = st_q;
        st_d.instr_stb = 1'b0;
        st_d.wdata_stb = 1'b0;
        st_d.step_stb  = 1'b0;
        st_d.done_stb  = 1'b0;
        byte_nx        = {st_q.sh[BYTE_W-2:0], sda_f};
        sh_ld          = {{(BYTE_W-RD_W){1'b0}}, rd_val_i};

        if (ev.stop) begin
            st_d.phase     = PH_IDLE;
            st_d.oe        = 1'b0;
            st_d.done_stb  = st_q.complete;
            st_d.complete  = 1'b0;
            st_d.byte_done = 1'b0;
        end else if (ev.start) begin
            st_d.phase     = PH_ADDR;
            st_d.cnt       = '0;
            st_d.oe        = 1'b0;
            st_d.complete  = 1'b0;
            st_d.byte_done = 1'b0;
        end else begin
            case (st_q.phase)
                PH_ADDR, PH_INSTR, PH_WDATA: begin
                    if (ev.scl_rise && !st_q.byte_done) begin
                        st_d.sh  = byte_nx;
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (st_q.cnt == LAST_BIT) begin
                            st_d.byte_done = 1'b1;
                            if (st_q.phase == PH_ADDR) begin
                                st_d.ack       = (byte_nx[7:4] == TYPE_ID) &&
                                                 (byte_nx[3:0] == dev_addr_i) && !nv_busy_i;
                                st_d.after_ack = PH_INSTR;
                            end else if (st_q.phase == PH_INSTR) begin
                                st_d.ack       = 1'b1;
                                st_d.op        = byte_nx[7:4];
                                st_d.ptr       = byte_nx[3:0];
                                st_d.instr_stb = 1'b1;
                                st_d.after_ack = phase_after_instr(byte_nx[7:4]);
                            end else begin
                                st_d.ack       = 1'b1;
                                st_d.wdata     = byte_nx;
                                st_d.wdata_stb = 1'b1;
                                st_d.after_ack = PH_HOLD;
                            end
                        end
                    end else if (ev.scl_fall && st_q.byte_done) begin
                        st_d.byte_done = 1'b0;
                        st_d.cnt       = '0;
                        if (st_q.ack) begin
                            st_d.phase = PH_ACK;
                            st_d.oe    = 1'b1;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        st_d.oe    = 1'b0;
                        st_d.cnt   = '0;
                        st_d.phase = st_q.after_ack;
                        if (st_q.after_ack == PH_RDATA) begin
                            st_d.sh = sh_ld;
                            st_d.oe = ~sh_ld[BYTE_W-1];
                        end else if (st_q.after_ack == PH_HOLD || st_q.after_ack == PH_STEP) begin
                            st_d.complete = 1'b1;
                        end
                    end
                end
                PH_RDATA: begin
                    if (ev.scl_fall) begin
                        if (st_q.cnt == LAST_BIT) begin
                            st_d.oe    = 1'b0;
                            st_d.phase = PH_MACK;
                        end else begin
                            st_d.sh  = {st_q.sh[BYTE_W-2:0], 1'b0};
                            st_d.oe  = ~st_q.sh[BYTE_W-2];
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.scl_fall) begin
                        st_d.phase    = PH_HOLD;
                        st_d.complete = 1'b1;
                    end
                end
                PH_STEP: begin
                    if (ev.scl_rise) begin
                        st_d.dir = sda_f;
                    end else if (ev.scl_fall) begin
                        st_d.step_stb = 1'b1;
                        st_d.step_up  = st_q.dir;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o    = st_q.oe;
    assign instr_stb_o = st_q.instr_stb;
    assign opcode_o    = st_q.op;
    assign pointer_o   = st_q.ptr;
    assign wdata_stb_o = st_q.wdata_stb;
    assign wdata_o     = st_q.wdata;
    assign step_stb_o  = st_q.step_stb;
    assign step_up_o   = st_q.step_up;
    assign cmd_done_o  = st_q.done_stb;

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_f); // R11
    AST_STEP_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb_o |-> !scl_f); // R9
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |-> !sda_oe_o); // R10
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_stb_o, wdata_stb_o, step_stb_o, cmd_done_o})); // R6

endmodule

// File: rtl/twowire_slave_fe.sv
module twowire_slave_fe
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int RD_W        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [3:0]      dev_addr_i,
    input  logic            nv_busy_i,
    input  logic [RD_W-1:0] rd_val_i,
    output logic            sda_oe_o,
    output logic            instr_stb_o,
    output logic [3:0]      opcode_o,
    output logic [3:0]      pointer_o,
    output logic            wdata_stb_o,
    output logic [7:0]      wdata_o,
    output logic            step_stb_o,
    output logic            step_up_o,
    output logic            cmd_done_o
);

    localparam int N_LINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] filt;
    bus_ev_t            ev;

    assign raw[IDX_SCL] = scl_i;
    assign raw[IDX_SDA] = sda_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tw_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw[g]),
            .line_o(filt[g])
        );
    end

    tw_bus_events u_ev (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(filt[IDX_SCL]),
        .sda_f(filt[IDX_SDA]),
        .ev_o (ev)
    );

    tw_slave_fsm #(
        .RD_W(RD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .scl_f      (filt[IDX_SCL]),
        .sda_f      (filt[IDX_SDA]),
        .dev_addr_i (dev_addr_i),
        .nv_busy_i  (nv_busy_i),
        .rd_val_i   (rd_val_i),
        .sda_oe_o   (sda_oe_o),
        .instr_stb_o(instr_stb_o),
        .opcode_o   (opcode_o),
        .pointer_o  (pointer_o),
        .wdata_stb_o(wdata_stb_o),
        .wdata_o    (wdata_o),
        .step_stb_o (step_stb_o),
        .step_up_o  (step_up_o),
        .cmd_done_o (cmd_done_o)
    );

endmodule

// File: tb/tb_twowire_slave_fe.sv
module tb_twowire_slave_fe;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int N_RAND     = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       glitch = 1'b0;
    logic [3:0] dev_addr = 4'hA;
    logic       busy = 1'b0;
    logic [5:0] rd_val = '0;
    logic       sda_bus;
    logic       sda_oe, instr_stb, wdata_stb, step_stb, step_up, cmd_done;
    logic [3:0] opcode, pointer;
    logic [7:0] wdata;

    int n_chk = 0, n_fail = 0;
    int n_instr = 0, n_wdata = 0, n_step = 0, n_up = 0, n_done = 0, n_oe_bad = 0;
    logic oe_prev = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twowire_slave_fe dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus ^ glitch),
        .dev_addr_i(dev_addr), .nv_busy_i(busy), .rd_val_i(rd_val),
        .sda_oe_o(sda_oe), .instr_stb_o(instr_stb), .opcode_o(opcode), .pointer_o(pointer),
        .wdata_stb_o(wdata_stb), .wdata_o(wdata), .step_stb_o(step_stb), .step_up_o(step_up),
        .cmd_done_o(cmd_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (instr_stb) n_instr++;
            if (wdata_stb) n_wdata++;
            if (step_stb) begin
                n_step++;
                if (step_up) n_up++;
            end
            if (cmd_done) n_done++;
            if (sda_oe && !oe_prev && scl_m) n_oe_bad++;
            oe_prev = sda_oe;
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        report();
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, input logic glitch_en, output logic seen);
        sda_m = b;
        wait_clk(Q);
        scl_m = 1'b1;
        if (glitch_en) begin
            wait_clk(3);
            glitch = 1'b1;
            wait_clk(2);
            glitch = 1'b0;
            wait_clk(Q - 5);
        end else begin
            wait_clk(Q);
        end
        seen = sda_bus;
        wait_clk(Q);
        scl_m = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(Q);
        scl_m = 1'b1;
        wait_clk(Q);
        sda_m = 1'b0;
        wait_clk(Q);
        scl_m = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(Q);
        scl_m = 1'b1;
        wait_clk(Q);
        sda_m = 1'b1;
        wait_clk(2 * Q);
    endtask

    task automatic write_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
        logic seen;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], (i == glitch_bit), seen);
        clock_bit(1'b1, 1'b0, seen);
        ack = ~seen;
    endtask

    task automatic read_byte(output logic [7:0] d);
        logic seen;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, 1'b0, seen);
            d[i] = seen;
        end
        clock_bit(1'b1, 1'b0, seen);
    endtask

    function automatic logic exp_addr_ack(input logic [7:0] a, input logic [3:0] pins, input logic bsy);
        return (a[7:4] == 4'b0101) && (a[3:0] == pins) && !bsy;
    endfunction

    // 0: two-byte, 1: write data, 2: read, 3: stepping
    function automatic int exp_kind(input logic [3:0] op);
        if (op == 4'b1010 || op == 4'b1100) return 1;
        if (op == 4'b1001 || op == 4'b1011) return 2;
        if (op == 4'b0010) return 3;
        return 0;
    endfunction

    task automatic run_trans(input logic [7:0] addr_b, input logic busy_v, input logic [3:0] op,
                             input logic [3:0] ptr, input logic [7:0] data, input int nsteps,
                             input logic [7:0] dirs);
        logic ack, a2, ex;
        logic [7:0] rd;
        int s_instr, s_wdata, s_step, s_up, s_done, exp_up;
        string tag;
        s_instr = n_instr; s_wdata = n_wdata; s_step = n_step; s_up = n_up; s_done = n_done;
        ex = exp_addr_ack(addr_b, dev_addr, busy_v);
        if (addr_b[7:4] != 4'b0101 || addr_b[3:0] != dev_addr) tag = "R4 addr mismatch";
        else if (busy_v) tag = "R5 busy nack";
        else tag = "R3 addr ack";
        busy = busy_v;
        bus_start();
        write_byte(addr_b, -1, ack);
        busy = 1'b0;
        chk(tag, ack, ex);
        write_byte({op, ptr}, -1, a2);
        wait_clk(2);
        if (ex) begin
            chk("R6 instr ack", a2, 1);
            chk("R6 instr strobe count", n_instr - s_instr, 1);
            chk("R6 opcode/pointer", {opcode, pointer}, {op, ptr});
            case (exp_kind(op))
                1: begin
                    write_byte(data, -1, a2);
                    wait_clk(2);
                    chk("R7 data ack", a2, 1);
                    chk("R7 wdata", {n_wdata - s_wdata, wdata}, {1, data});
                end
                2: begin
                    read_byte(rd);
                    chk("R8 read byte", rd, {2'b00, rd_val});
                end
                3: begin
                    exp_up = 0;
                    for (int k = 0; k < nsteps; k++) begin
                        clock_bit(dirs[k], 1'b0, a2);
                        if (dirs[k]) exp_up++;
                    end
                    wait_clk(2);
                    chk("R9 step count", n_step - s_step, nsteps);
                    chk("R9 up count", n_up - s_up, exp_up);
                end
                default: ;
            endcase
        end else begin
            chk("R4 no ack after mismatch", a2, 0);
            chk("R4 no strobe after mismatch", n_instr - s_instr, 0);
        end
        bus_stop();
        chk("R10 done on stop", n_done - s_done, ex ? 1 : 0);
    endtask

    initial begin
        logic ack;
        int s_step, s_up, s_done, s_instr;
        logic [3:0] ops [10];
        ops = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b0010,
                4'b1101, 4'b1110, 4'b0001, 4'b1000, 4'b0111};
        void'($urandom(32'd5150));

        wait_clk(5);
        chk("R2 reset oe", sda_oe, 0);
        chk("R2 reset strobes", {instr_stb, wdata_stb, step_stb, cmd_done}, 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk("R2 idle oe", sda_oe, 0);

        // directed cases
        run_trans({4'b0101, dev_addr}, 1'b0, 4'b1101, 4'h6, 8'h00, 0, 8'h00);
        run_trans({4'b0101, dev_addr}, 1'b1, 4'b1010, 4'h1, 8'h33, 0, 8'h00);
        run_trans({4'b0110, dev_addr}, 1'b0, 4'b1010, 4'h1, 8'h33, 0, 8'h00);
        run_trans({4'b0101, dev_addr ^ 4'b1000}, 1'b0, 4'b1001, 4'h2, 8'h00, 0, 8'h00);
        rd_val = 6'h3F;
        run_trans({4'b0101, dev_addr}, 1'b0, 4'b1011, 4'h9, 8'h00, 0, 8'h00);
        rd_val = 6'h00;
        run_trans({4'b0101, dev_addr}, 1'b0, 4'b1001, 4'h3, 8'h00, 0, 8'h00);
        run_trans({4'b0101, dev_addr}, 1'b0, 4'b1100, 4'hF, 8'hFF, 0, 8'h00);
        run_trans({4'b0101, dev_addr}, 1'b0, 4'b0010, 4'h1, 8'h00, 0, 8'h00);

        // R1: short glitch on SDA during an address byte
        s_instr = n_instr;
        bus_start();
        write_byte({4'b0101, 4'b1111}, 1, ack);  // dev_addr still 4'hA: bit 1 is high
        chk("R1 glitch on mismatch stays ignored", ack, 0);
        bus_stop();
        bus_start();
        write_byte({4'b0101, dev_addr}, 3, ack);
        chk("R1 glitch ignored, addr ack", ack, 1);
        write_byte(8'hD0, -1, ack);
        wait_clk(2);
        chk("R1 instr after glitch", n_instr - s_instr, 1);
        bus_stop();

        // R10: stop after address only
        s_done = n_done;
        bus_start();
        write_byte({4'b0101, dev_addr}, -1, ack);
        bus_stop();
        chk("R10 no done on incomplete command", n_done - s_done, 0);

        // R9 + R2: stepping interrupted by a repeated start
        s_step = n_step; s_up = n_up; s_done = n_done;
        bus_start();
        write_byte({4'b0101, dev_addr}, -1, ack);
        write_byte({4'b0010, 4'h0}, -1, ack);
        clock_bit(1'b1, 1'b0, ack);
        clock_bit(1'b1, 1'b0, ack);
        clock_bit(1'b0, 1'b0, ack);
        bus_start();
        write_byte({4'b0101, dev_addr}, -1, ack);
        chk("R2 repeated start addr ack", ack, 1);
        write_byte(8'hE1, -1, ack);
        bus_stop();
        chk("R9 steps before repeated start", n_step - s_step, 3);
        chk("R9 up steps before repeated start", n_up - s_up, 2);
        chk("R10 single done after restart", n_done - s_done, 1);

        // random transactions
        for (int t = 0; t < N_RAND; t++) begin
            logic [7:0] a;
            logic [3:0] op;
            dev_addr = 4'($urandom);
            rd_val   = 6'($urandom);
            a = ($urandom % 4 != 0) ? {4'b0101, dev_addr} : 8'($urandom);
            op = ops[$urandom % 10];
            run_trans(a, ($urandom % 5 == 0), op, 4'($urandom), 8'($urandom),
                      int'($urandom % 6), 8'($urandom));
        end

        chk("R11 oe rose only with SCL low", n_oe_bad, 0);
        report();
    end

endmodule